// File: doc/BRIEF.md
# Timer Interrupt Flag Controller

This block gathers single-cycle event pulses from the channels of a multi-channel timer into sticky status flags, and raises one interrupt request whenever a flag is set and its enable bit is on. Eight flags in the first flag register come from the output-compare and input-capture channels. Four flags in the second flag register come from the counter overflow, the real-time tick, the pulse-accumulator overflow and the pulse-accumulator edge. Each flag register has a companion enable register with the same bit layout. The second enable register also holds the two select bits that the prescaler outside this block uses.

Software reaches the four registers through a plain single-cycle register port. A write takes effect on the clock edge where `reg_wr` is high. Reads are combinational from `reg_addr`. The port never stalls, so it has no valid/ready handshake. A flag is cleared only by writing a one to its position. Writing a zero leaves the flag as it is. One flag position is shared between input capture 4 and output compare 5, and a select input decides which of the two events can set it.

Register addresses: 0 = flag register 1, 1 = enable register 1, 2 = flag register 2, 3 = enable register 2.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: After reset all four registers read 0x00, `irq` is 0 and `presc_sel` is 0.
- R2: A pulse on `oc_evt[i]`, for i from 0 to 3, sets bit 7-i of flag register 1 at the next clock edge.
- R3: A pulse on `ic_evt[i]`, for i from 0 to 2, sets bit 2-i of flag register 1 at the next clock edge.
- R4: Bit 3 of flag register 1 is set by `ic_evt[3]` when `ic4_sel` is 1 and by `oc_evt[4]` when `ic4_sel` is 0. The event that is not selected changes no flag.
- R5: `ovf_evt`, `rti_evt`, `paov_evt` and `pai_evt` set bits 7, 6, 5 and 4 of flag register 2. Bits 3 to 0 of flag register 2 always read 0.
- R6: Writing to a flag register clears every flag whose data bit is 1 and leaves every flag whose data bit is 0 unchanged.
- R7: When a set event and a write-one clear reach the same flag in the same cycle, the flag reads 1 afterwards.
- R8: Enable register 1 reads back all eight written bits. Enable register 2 reads back bits 7 to 4 and 1 to 0, and bits 3 and 2 read 0.
- R9: `irq` is the OR over both register pairs of each flag ANDed with the enable bit in the same position. It follows the registered flags and enables with no added clock delay.
- R10: `presc_sel` equals bits 1 to 0 of enable register 2 and changes only when that register is written.
- R11: A flag that is already set stays set when `ic4_sel` changes.
- R12: Without a set event or a clear write, every flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| oc_evt | input | 5 | Output-compare match pulses, bit i = channel i+1 |
| ic_evt | input | 4 | Input-capture edge pulses, bit i = channel i+1 |
| ovf_evt | input | 1 | Counter overflow pulse |
| rti_evt | input | 1 | Real-time tick pulse |
| paov_evt | input | 1 | Pulse-accumulator overflow pulse |
| pai_evt | input | 1 | Pulse-accumulator input edge pulse |
| ic4_sel | input | 1 | 1: capture 4 owns the shared flag; 0: compare 5 owns it |
| irq | output | 1 | Interrupt request |
| presc_sel | output | 2 | Prescaler select bits from enable register 2 |

## Verification
A wrong flag bit shows on `reg_rdata` for flag address 0 or 2 on the first read after the edge that corrupted it. It also shows on `irq` in the same cycle when its enable bit is on. A flag that was lost or set by mistake never repairs itself, because flags are sticky. So a check made any time before the next clear still catches it. A wrong enable bit shows both on read-back and on `irq`, and bits 1 to 0 of enable register 2 appear at once on `presc_sel`. The sweeps drive every write pattern against fully set flags and every enable pattern against each single flag, so a swapped, stuck or wrongly gated position shows in a pattern whose result can be computed.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 2;
  localparam int N_OC   = 5;
  localparam int N_IC   = 4;
  // compare channels with a dedicated flag (the last one shares)
  localparam int N_OC_DED = N_OC - 1;
  // capture channels with a dedicated flag (the last one shares)
  localparam int N_IC_DED = N_IC - 1;
  localparam int SHARED_BIT = N_IC_DED;

  typedef enum logic [ADDR_W-1:0] {
    A_FLAG1 = 2'd0,
    A_MASK1 = 2'd1,
    A_FLAG2 = 2'd2,
    A_MASK2 = 2'd3
  } reg_addr_e;

  // bits that physically exist in each register
  localparam logic [REG_W-1:0] F1_IMPL = 8'hFF;
  localparam logic [REG_W-1:0] M1_IMPL = 8'hFF;
  localparam logic [REG_W-1:0] F2_IMPL = 8'hF0;
  localparam logic [REG_W-1:0] M2_IMPL = 8'hF3;

  localparam int PRESC_W = 2;
endpackage

// File: rtl/tmr_evt_map.sv
module tmr_evt_map
  import tmr_irq_pkg::*;
(
  input  logic [N_OC-1:0]  oc_evt,
  input  logic [N_IC-1:0]  ic_evt,
  input  logic             ovf_evt,
  input  logic             rti_evt,
  input  logic             paov_evt,
  input  logic             pai_evt,
  input  logic             ic4_sel,
  output logic [REG_W-1:0] set1,
  output logic [REG_W-1:0] set2
);
  // dedicated compare channels fill the top of register 1, channel 1 highest
  for (genvar i = 0; i < N_OC_DED; i++) begin : g_oc
    assign set1[REG_W-1-i] = oc_evt[i];
  end

  // dedicated capture channels fill the bottom, channel 1 highest
  for (genvar i = 0; i < N_IC_DED; i++) begin : g_ic
    assign set1[N_IC_DED-1-i] = ic_evt[i];
  end

  // shared position: only the selected source reaches it
  assign set1[SHARED_BIT] = ic4_sel ? ic_evt[N_IC-1] : oc_evt[N_OC-1];

  assign set2 = {ovf_evt, rti_evt, paov_evt, pai_evt, {(REG_W-4){1'b0}}};
endmodule

// File: rtl/tmr_flag_reg.sv
module tmr_flag_reg #(
  parameter int            W    = 8,
  parameter logic [W-1:0]  IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic         clr_we,
  input  logic [W-1:0] clr_data,
  output logic [W-1:0] q
);
  logic [W-1:0] clr_vec;
  logic [W-1:0] state_d;

  always_comb begin
    clr_vec = clr_we ? clr_data : '0;
    // a set in the same cycle overrides the clear
    state_d = (set | (q & ~clr_vec)) & IMPL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= state_d;
  end
endmodule

// File: rtl/tmr_mask_reg.sv
module tmr_mask_reg #(
  parameter int            W    = 8,
  parameter logic [W-1:0]  IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata & IMPL;
  end
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
  import tmr_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [N_OC-1:0]   oc_evt,
  input  logic [N_IC-1:0]   ic_evt,
  input  logic              ovf_evt,
  input  logic              rti_evt,
  input  logic              paov_evt,
  input  logic              pai_evt,
  input  logic              ic4_sel,
  output logic              irq,
  output logic [PRESC_W-1:0] presc_sel
);
  logic [REG_W-1:0] set1, set2;
  logic [REG_W-1:0] flag1_q, flag2_q, mask1_q, mask2_q;
  logic             we_f1, we_m1, we_f2, we_m2;
  reg_addr_e        addr_e;

  assign addr_e = reg_addr_e'(reg_addr);
  assign we_f1  = reg_wr && (addr_e == A_FLAG1);
  assign we_m1  = reg_wr && (addr_e == A_MASK1);
  assign we_f2  = reg_wr && (addr_e == A_FLAG2);
  assign we_m2  = reg_wr && (addr_e == A_MASK2);

  tmr_evt_map u_map (
    .oc_evt   (oc_evt),
    .ic_evt   (ic_evt),
    .ovf_evt  (ovf_evt),
    .rti_evt  (rti_evt),
    .paov_evt (paov_evt),
    .pai_evt  (pai_evt),
    .ic4_sel  (ic4_sel),
    .set1     (set1),
    .set2     (set2)
  );

  tmr_flag_reg #(.W(REG_W), .IMPL(F1_IMPL)) u_flag1 (
    .clk (clk), .rst_n (rst_n), .set (set1),
    .clr_we (we_f1), .clr_data (reg_wdata), .q (flag1_q)
  );

  tmr_flag_reg #(.W(REG_W), .IMPL(F2_IMPL)) u_flag2 (
    .clk (clk), .rst_n (rst_n), .set (set2),
    .clr_we (we_f2), .clr_data (reg_wdata), .q (flag2_q)
  );

  tmr_mask_reg #(.W(REG_W), .IMPL(M1_IMPL)) u_mask1 (
    .clk (clk), .rst_n (rst_n), .we (we_m1), .wdata (reg_wdata), .q (mask1_q)
  );

  tmr_mask_reg #(.W(REG_W), .IMPL(M2_IMPL)) u_mask2 (
    .clk (clk), .rst_n (rst_n), .we (we_m2), .wdata (reg_wdata), .q (mask2_q)
  );

  always_comb begin
    unique case (addr_e)
      A_FLAG1: reg_rdata = flag1_q;
      A_MASK1: reg_rdata = mask1_q;
      A_FLAG2: reg_rdata = flag2_q;
      A_MASK2: reg_rdata = mask2_q;
      default: reg_rdata = '0;
    endcase
  end

  assign irq       = |(flag1_q & mask1_q) | |(flag2_q & mask2_q & F2_IMPL);
  assign presc_sel = mask2_q[PRESC_W-1:0];
endmodule

// File: rtl/tmr_irq_ctrl_chk.sv
module tmr_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic       wdata7,
  input logic [3:0] rdata_lo,
  input logic       oc1,
  input logic       oc5,
  input logic       ic1,
  input logic       ic4,
  input logic       ic4_sel,
  input logic       irq,
  input logic [1:0] presc_sel,
  input logic [7:0] flag1_q,
  input logic [7:0] mask1_q,
  input logic [3:0] mask2_hi
);
  // R2
  oc1_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oc1 |=> flag1_q[7]);
  // R3
  ic1_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ic1 |=> flag1_q[2]);
  // R4
  shared_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ic4_sel && ic4 && !oc5 && !flag1_q[3]) |=> !flag1_q[3]);
  // R5
  flag2_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd2) |-> (rdata_lo == 4'h0));
  // R6
  clear_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0 && wdata7 && !oc1) |=> !flag1_q[7]);
  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0 && wdata7 && oc1) |=> flag1_q[7]);
  // R8
  mask2_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd3) |-> (rdata_lo[3:2] == 2'b00));
  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask1_q == 8'h00 && mask2_hi == 4'h0) |-> !irq);
  // R10
  presc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == 2'd3) |=> $stable(presc_sel));
  // R12
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == 2'd0) |=> ((flag1_q & $past(flag1_q)) == $past(flag1_q)));
endmodule

bind tmr_irq_ctrl tmr_irq_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .wdata7    (reg_wdata[7]),
  .rdata_lo  (reg_rdata[3:0]),
  .oc1       (oc_evt[0]),
  .oc5       (oc_evt[4]),
  .ic1       (ic_evt[0]),
  .ic4       (ic_evt[3]),
  .ic4_sel   (ic4_sel),
  .irq       (irq),
  .presc_sel (presc_sel),
  .flag1_q   (flag1_q),
  .mask1_q   (mask1_q),
  .mask2_hi  (mask2_q[7:4])
);

// File: tb/tmr_irq_ctrl_bench.sv
`timescale 1ns/1ps
module tmr_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [4:0] oc_evt = '0;
  logic [3:0] ic_evt = '0;
  logic       ovf_evt = 1'b0, rti_evt = 1'b0, paov_evt = 1'b0, pai_evt = 1'b0;
  logic       ic4_sel = 1'b1;
  logic       irq;
  logic [1:0] presc_sel;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tmr_irq_ctrl u_tmr_irq_ctrl (
    .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_addr (reg_addr),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .oc_evt (oc_evt),
    .ic_evt (ic_evt), .ovf_evt (ovf_evt), .rti_evt (rti_evt),
    .paov_evt (paov_evt), .pai_evt (pai_evt), .ic4_sel (ic4_sel),
    .irq (irq), .presc_sel (presc_sel)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // read is combinational: set address just after a falling edge, sample 1 ns later
  task automatic rd_check(input string req, input logic [1:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 8'h00;
  endtask

  // f2 = {ovf, rti, paov, pai}
  task automatic pulse(input logic [4:0] oc, input logic [3:0] ic, input logic [3:0] f2);
    @(negedge clk);
    oc_evt = oc; ic_evt = ic;
    {ovf_evt, rti_evt, paov_evt, pai_evt} = f2;
    @(negedge clk);
    oc_evt = '0; ic_evt = '0;
    {ovf_evt, rti_evt, paov_evt, pai_evt} = 4'h0;
  endtask

  task automatic set_all;
    ic4_sel = 1'b1;
    pulse(5'h1F, 4'hF, 4'hF);
  endtask

  task automatic clear_all;
    wr_reg(2'd0, 8'hFF);
    wr_reg(2'd2, 8'hFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    rd_check("R1", 2'd0, 8'h00);
    rd_check("R1", 2'd1, 8'h00);
    rd_check("R1", 2'd2, 8'h00);
    rd_check("R1", 2'd3, 8'h00);
    check("R1", {7'd0, irq}, 8'h00);
    check("R1", {6'd0, presc_sel}, 8'h00);
    rst_n = 1'b1;

    // R2 dedicated compare channels
    for (int i = 0; i < 4; i++) begin
      pulse(5'(1 << i), 4'h0, 4'h0);
      rd_check("R2", 2'd0, 8'(8'h80 >> i));
      wr_reg(2'd0, 8'hFF);
      rd_check("R6", 2'd0, 8'h00);
    end

    // R3 dedicated capture channels
    for (int i = 0; i < 3; i++) begin
      pulse(5'h00, 4'(1 << i), 4'h0);
      rd_check("R3", 2'd0, 8'(8'h04 >> i));
      wr_reg(2'd0, 8'hFF);
    end

    // R4 shared position under both selections
    ic4_sel = 1'b1;
    pulse(5'h10, 4'h0, 4'h0);
    rd_check("R4 compare5 deselected", 2'd0, 8'h00);
    pulse(5'h00, 4'h8, 4'h0);
    rd_check("R4 capture4 selected", 2'd0, 8'h08);
    wr_reg(2'd0, 8'hFF);
    ic4_sel = 1'b0;
    pulse(5'h00, 4'h8, 4'h0);
    rd_check("R4 capture4 deselected", 2'd0, 8'h00);
    rd_check("R4 capture4 deselected", 2'd2, 8'h00);
    pulse(5'h10, 4'h0, 4'h0);
    rd_check("R4 compare5 selected", 2'd0, 8'h08);

    // R11 flag survives a select change
    ic4_sel = 1'b1;
    repeat (3) @(negedge clk);
    rd_check("R11", 2'd0, 8'h08);
    wr_reg(2'd0, 8'hFF);

    // R5 second flag register sources
    for (int k = 0; k < 4; k++) begin
      pulse(5'h00, 4'h0, 4'(4'h8 >> k));
      rd_check("R5", 2'd2, 8'(8'h80 >> k));
      rd_check("R5", 2'd0, 8'h00);
      wr_reg(2'd2, 8'hFF);
    end
    pulse(5'h00, 4'h0, 4'hF);
    rd_check("R5 low bits", 2'd2, 8'hF0);

    // R12 flags hold while idle
    set_all;
    repeat (5) @(negedge clk);
    rd_check("R12", 2'd0, 8'hFF);
    rd_check("R12", 2'd2, 8'hF0);

    // R6 exhaustive clear patterns against fully set flags
    for (int p = 0; p < 256; p++) begin
      set_all;
      wr_reg(2'd0, 8'(p));
      rd_check("R6 flag1", 2'd0, ~8'(p));
      wr_reg(2'd2, 8'(p));
      rd_check("R6 flag2", 2'd2, 8'hF0 & ~8'(p));
    end

    // R7 set beats same-cycle clear
    set_all;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'hFF; oc_evt = 5'h01;
    @(negedge clk);
    reg_wr = 1'b0; oc_evt = '0;
    rd_check("R7 flag1", 2'd0, 8'h80);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 8'hFF; ovf_evt = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; ovf_evt = 1'b0;
    rd_check("R7 flag2", 2'd2, 8'h80);
    clear_all;

    // R8 / R10 enable read-back and prescaler bits
    for (int m = 0; m < 256; m++) begin
      wr_reg(2'd1, 8'(m));
      rd_check("R8 enable1", 2'd1, 8'(m));
      wr_reg(2'd3, 8'(m));
      rd_check("R8 enable2", 2'd3, 8'(m) & 8'hF3);
      check("R10", {6'd0, presc_sel}, {6'd0, 2'(m)});
    end
    wr_reg(2'd0, 8'hFF);
    check("R10 hold", {6'd0, presc_sel}, 8'h03);
    wr_reg(2'd1, 8'h00);
    wr_reg(2'd3, 8'h00);

    // R9 each single flag of register 1 against every enable pattern
    for (int b = -1; b < 8; b++) begin
      logic [7:0] f;
      f = (b < 0) ? 8'h00 : 8'(1 << b);
      set_all;
      wr_reg(2'd0, ~f);
      wr_reg(2'd2, 8'hFF);
      for (int m = 0; m < 256; m++) begin
        wr_reg(2'd1, 8'(m));
        check("R9 pair1", {7'd0, irq}, {7'd0, |(f & 8'(m))});
      end
    end
    wr_reg(2'd1, 8'h00);
    clear_all;

    // R9 each flag of register 2 against every enable pattern
    for (int k = 0; k < 4; k++) begin
      pulse(5'h00, 4'h0, 4'(4'h8 >> k));
      for (int m = 0; m < 256; m++) begin
        wr_reg(2'd3, 8'(m));
        check("R9 pair2", {7'd0, irq}, {7'd0, |(8'(8'h80 >> k) & 8'(m))});
      end
      wr_reg(2'd2, 8'hFF);
    end
    wr_reg(2'd3, 8'h00);

    // R9 no added delay: irq rises with the flag edge
    wr_reg(2'd1, 8'h80);
    check("R9 idle", {7'd0, irq}, 8'h00);
    pulse(5'h01, 4'h0, 4'h0);
    check("R9 same cycle", {7'd0, irq}, 8'h01);
    wr_reg(2'd0, 8'h80);
    check("R9 cleared", {7'd0, irq}, 8'h00);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule